// File: doc/BRIEF.md
# Eight-bit ALU with carry, sign, zero and parity flags

This block is a self-contained arithmetic/logic unit for a small 8-bit processor data path. It keeps its own two operand registers, A and B, separate from any general register file. Each is loaded through its own strobe. A 4-bit operation code selects one of twelve functions: add, add with carry, subtract, subtract with borrow, AND, XOR, XNOR, compare, zero-fill shifts left and right, and rotates left and right through the carry flag. Subtraction runs on the same adder, with B inverted and the carry-in adjusted. The carry flag reports a carry on addition and a borrow on subtraction.

A `go` strobe starts an operation on the operand values held at that edge. The 8-bit result is registered on the same edge. Compare is the exception: it leaves the result register untouched. The four flags are registered only when `go` and `flag_en` are both high. This lets the surrounding controller compute a value without disturbing the condition codes that a later conditional jump will test.

Top module: `alu8_unit`

## Requirements
- R1: After a synchronous active-high reset, `result`, A, B and all four flags are 0.
- R2: `a_ld` loads `a_din` into A and `b_ld` loads `b_din` into B on the clock edge. An operation started on the same edge uses the values that A and B held before that edge.
- R3: Opcode 0 (ADD) gives A+B mod 256 and opcode 1 (ADC) gives A+B+CF mod 256. In both, CF is set to the carry out of bit 7.
- R4: Opcode 2 (SUB) gives A-B mod 256 and opcode 3 (SBC) gives A-B-CF mod 256. In both, CF is 1 exactly when a borrow occurs, i.e. the true difference is negative.
- R5: Opcode 4 (AND), opcode 5 (XOR) and opcode 6 (XNOR) give the bitwise result and clear CF.
- R6: Opcode 7 (CMP) sets all four flags exactly as SUB would, and leaves `result` unchanged.
- R7: Opcode 8 shifts A left and opcode 9 shifts A right, each filling with 0. The bit shifted out goes to CF.
- R8: Opcode 10 rotates A left through carry: old bit 7 goes to CF and old CF enters bit 0. Opcode 11 is the mirror image: old bit 0 goes to CF and old CF enters bit 7.
- R9: On every flag update, ZF = (value == 0), SF = bit 7 of the value, and PF = 1 when the value holds an even number of 1 bits. The value is the result, or the difference for CMP.
- R10: Flags change only on an edge where `go` and `flag_en` are both 1. With `go` high and `flag_en` low, the result is written and the flags hold.
- R11: Opcodes 12 to 15 change neither `result` nor any flag.
- R12: `result` and the flags are registered. They reflect an operation from the edge on which `go` was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_ld | input | 1 | Load strobe for operand A |
| a_din | input | 8 | Data for operand A |
| b_ld | input | 1 | Load strobe for operand B |
| b_din | input | 8 | Data for operand B |
| op | input | 4 | Operation code |
| go | input | 1 | Perform the operation this edge |
| flag_en | input | 1 | Allow the flags to update with `go` |
| result | output | 8 | Registered result |
| cf | output | 1 | Carry / borrow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Even-parity flag |

## Verification
The bench builds the block at its default width of 8 bits. At that width, the carry and borrow boundaries (0x00, 0x7F, 0x80, 0xFF) and every parity pattern are reachable with a short directed list followed by a long pseudo-random stream. The behavioural model chains operations, so the carry left by one step feeds the ADC, SBC and rotate of the next. This exposes any stale or misrouted carry. Runs with `flag_en` low and with reserved opcodes are mixed into the stream, which checks that the flags hold between updates.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_XNOR = 4'd6,
    OP_CMP  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_RLC  = 4'd10,
    OP_RRC  = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic p;
  } alu_flags_t;

endpackage

// File: rtl/alu8_opreg.sv
module alu8_opreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= din;
  end

  // R2
  opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         inv_y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0] y_eff;
  logic [W:0]   ripple;

  assign ripple[0] = cin;

  // Operand inversion and full-adder chain, one cell per bit
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign y_eff[i]    = y[i] ^ inv_y;
    assign sum[i]      = x[i] ^ y_eff[i] ^ ripple[i];
    assign ripple[i+1] = (x[i] & y_eff[i]) | (ripple[i] & (x[i] ^ y_eff[i]));
  end

  assign cout = ripple[W];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         cf_in,
  output logic [W-1:0] value,
  output logic         c_new,
  output logic         wr_res,
  output logic         wr_flg
);

  localparam int MSB = W - 1;

  logic         is_sub;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;

  always_comb begin
    is_sub  = 1'b0;
    add_cin = 1'b0;
    case (op)
      OP_ADC:         add_cin = cf_in;
      OP_SUB, OP_CMP: begin is_sub = 1'b1; add_cin = 1'b1;   end
      OP_SBC:         begin is_sub = 1'b1; add_cin = ~cf_in; end
      default:        ;
    endcase
  end

  alu8_adder #(.W(W)) u_adder (
    .x    (a),
    .y    (b),
    .inv_y(is_sub),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_comb begin
    value  = '0;
    c_new  = 1'b0;
    wr_res = 1'b1;
    wr_flg = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin value = add_sum; c_new = add_cout;  end
      OP_SUB, OP_SBC: begin value = add_sum; c_new = ~add_cout; end
      OP_CMP: begin value = add_sum; c_new = ~add_cout; wr_res = 1'b0; end
      OP_AND:  value = a & b;
      OP_XOR:  value = a ^ b;
      OP_XNOR: value = ~(a ^ b);
      OP_SHL:  begin value = {a[MSB-1:0], 1'b0};  c_new = a[MSB]; end
      OP_SHR:  begin value = {1'b0, a[MSB:1]};    c_new = a[0];   end
      OP_RLC:  begin value = {a[MSB-1:0], cf_in}; c_new = a[MSB]; end
      OP_RRC:  begin value = {cf_in, a[MSB:1]};   c_new = a[0];   end
      default: begin wr_res = 1'b0; wr_flg = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] value,
  input  logic         c_new,
  output alu_flags_t   flg
);

  alu_flags_t nxt;

  always_comb begin
    nxt.c = c_new;
    nxt.s = value[W-1];
    nxt.z = (value == '0);
    nxt.p = ~(^value);
  end

  always_ff @(posedge clk) begin
    if (rst)      flg <= '0;
    else if (upd) flg <= nxt;
  end

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flg));

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_ld,
  input  logic [W-1:0] a_din,
  input  logic         b_ld,
  input  logic [W-1:0] b_din,
  input  logic [3:0]   op,
  input  logic         go,
  input  logic         flag_en,
  output logic [W-1:0] result,
  output logic         cf,
  output logic         sf,
  output logic         zf,
  output logic         pf
);

  logic [W-1:0] a_q, b_q;
  logic [W-1:0] value;
  logic         c_new, wr_res, wr_flg;
  alu_flags_t   flg;

  alu8_opreg #(.W(W)) u_reg_a (
    .clk(clk), .rst(rst), .ld(a_ld), .din(a_din), .q(a_q)
  );

  alu8_opreg #(.W(W)) u_reg_b (
    .clk(clk), .rst(rst), .ld(b_ld), .din(b_din), .q(b_q)
  );

  alu8_core #(.W(W)) u_core (
    .a     (a_q),
    .b     (b_q),
    .op    (op),
    .cf_in (flg.c),
    .value (value),
    .c_new (c_new),
    .wr_res(wr_res),
    .wr_flg(wr_flg)
  );

  alu8_flags #(.W(W)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .upd  (go & flag_en & wr_flg),
    .value(value),
    .c_new(c_new),
    .flg  (flg)
  );

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (go && wr_res) result <= value;
  end

  assign cf = flg.c;
  assign sf = flg.s;
  assign zf = flg.z;
  assign pf = flg.p;

  logic op_writes;
  assign op_writes = (op <= 4'd6) || (op >= 4'd8 && op <= 4'd11);

  // R6
  cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    go && op == 4'd7 |=> $stable(result));

  // R11
  rsvd_nop_chk: assert property (@(posedge clk) disable iff (rst)
    go && op >= 4'd12 |=> $stable(result) && $stable({cf, sf, zf, pf}));

  // R5
  logic_cf_chk: assert property (@(posedge clk) disable iff (rst)
    go && flag_en && op >= 4'd4 && op <= 4'd6 |=> !cf);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    go && flag_en && op_writes |=> zf == (result == '0));

  // R9
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    go && flag_en && op_writes |=> sf == result[W-1]);

  // R9
  parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
    go && flag_en && op_writes |=> pf == ($countones(result) % 2 == 0));

  // R10
  no_flag_en_chk: assert property (@(posedge clk) disable iff (rst)
    !(go && flag_en) |=> $stable({cf, sf, zf, pf}));

endmodule

// File: tb/test_alu8_unit.sv
module test_alu8_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       a_ld, b_ld, go, flag_en;
  logic [7:0] a_din, b_din;
  logic [3:0] op;
  logic [7:0] result;
  logic       cf, sf, zf, pf;

  int checks = 0;
  int errors = 0;

  // model state
  int m_a, m_b, m_res, m_cf, m_sf, m_zf, m_pf;

  always #4 clk = ~clk;

  alu8_unit i_alu8_unit (
    .clk(clk), .rst(rst), .a_ld(a_ld), .a_din(a_din), .b_ld(b_ld),
    .b_din(b_din), .op(op), .go(go), .flag_en(flag_en),
    .result(result), .cf(cf), .sf(sf), .zf(zf), .pf(pf)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "result", result, m_res);
    check(tag, "cf", cf, m_cf);
    check(tag, "sf", sf, m_sf);
    check(tag, "zf", zf, m_zf);
    check(tag, "pf", pf, m_pf);
  endtask

  // behavioural update of the model for one edge
  task automatic model(input bit al, input int ad, input bit bl, input int bd,
                       input int o, input bit g, input bit fe);
    int v, c, ones;
    bit wres, wflg;
    v = 0; c = 0; wres = 1; wflg = 1;
    case (o)
      0: begin v = m_a + m_b;               c = v > 255; end
      1: begin v = m_a + m_b + m_cf;        c = v > 255; end
      2, 7: begin v = m_a - m_b;            c = v < 0;   end
      3: begin v = m_a - m_b - m_cf;        c = v < 0;   end
      4: v = m_a & m_b;
      5: v = m_a ^ m_b;
      6: v = ~(m_a ^ m_b);
      8: begin v = m_a * 2;                 c = m_a / 128; end
      9: begin v = m_a / 2;                 c = m_a % 2;   end
      10: begin v = m_a * 2 + m_cf;         c = m_a / 128; end
      11: begin v = m_a / 2 + 128 * m_cf;   c = m_a % 2;   end
      default: begin wres = 0; wflg = 0; end
    endcase
    v = v & 255;
    if (o == 7) wres = 0;
    if (g && wres) m_res = v;
    if (g && fe && wflg) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
      m_cf = c;
      m_sf = v / 128;
      m_zf = (v == 0);
      m_pf = (ones % 2 == 0);
    end
    if (al) m_a = ad;
    if (bl) m_b = bd;
  endtask

  task automatic step(input string tag, input bit al, input int ad, input bit bl,
                      input int bd, input int o, input bit g, input bit fe);
    @(negedge clk);
    a_ld = al; a_din = ad[7:0]; b_ld = bl; b_din = bd[7:0];
    op = o[3:0]; go = g; flag_en = fe;
    @(posedge clk);
    model(al, ad, bl, bd, o, g, fe);
    #2;
    compare(tag);
  endtask

  task automatic run(input string tag, input int a, input int b, input int o, input bit fe);
    step("R2", 1, a, 1, b, 0, 0, 0);
    step(tag, 0, 0, 0, 0, o, 1, fe);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; a_ld = 0; b_ld = 0; go = 0; flag_en = 0;
    a_din = 0; b_din = 0; op = 0;
    m_a = 0; m_b = 0; m_res = 0; m_cf = 0; m_sf = 0; m_zf = 0; m_pf = 0;
    repeat (3) @(posedge clk);
    #2;
    compare("R1");
    @(negedge clk);
    rst = 0;

    // R3 carry boundaries
    run("R3", 8'hFF, 8'h01, 0, 1);
    run("R3", 8'h7F, 8'h01, 1, 1);
    run("R3", 8'h80, 8'h80, 0, 1);
    run("R3", 8'h10, 8'h20, 1, 1);
    // R4 borrow boundaries
    run("R4", 8'h00, 8'h01, 2, 1);
    run("R4", 8'h00, 8'h00, 3, 1);
    run("R4", 8'h55, 8'h55, 2, 1);
    run("R4", 8'h80, 8'h7F, 3, 1);
    // R5 logic clears carry
    run("R4", 8'h00, 8'h01, 2, 1);
    run("R5", 8'hF0, 8'h0F, 4, 1);
    run("R5", 8'hA5, 8'h5A, 5, 1);
    run("R5", 8'hA5, 8'h5A, 6, 1);
    // R6 compare
    run("R3", 8'h12, 8'h34, 0, 1);
    run("R6", 8'h05, 8'h09, 7, 1);
    run("R6", 8'h09, 8'h09, 7, 1);
    // R7 shifts
    run("R7", 8'h81, 8'h00, 8, 1);
    run("R7", 8'h81, 8'h00, 9, 1);
    // R8 rotates through carry
    run("R8", 8'h80, 8'h00, 10, 1);
    run("R8", 8'h01, 8'h00, 10, 1);
    run("R8", 8'h01, 8'h00, 11, 1);
    run("R8", 8'h02, 8'h00, 11, 1);
    // R9 parity and sign patterns
    run("R9", 8'h03, 8'h00, 5, 1);
    run("R9", 8'h07, 8'h00, 5, 1);
    // R10 flags held without flag_en
    run("R4", 8'h00, 8'h01, 2, 1);
    run("R10", 8'h01, 8'h01, 4, 0);
    // R11 reserved opcodes
    for (int k = 12; k < 16; k++) run("R11", 8'h3C, 8'hC3, k, 1);
    // R2 same-edge load uses old value
    step("R2", 1, 8'h11, 1, 8'h22, 0, 0, 0);
    step("R2", 1, 8'hF0, 1, 8'h0F, 0, 1, 1);
    step("R12", 0, 0, 0, 0, 0, 0, 1);

    // chained pseudo-random stream
    for (int n = 0; n < 3000; n++) begin
      step("R12", ($urandom % 3) == 0, $urandom % 256, ($urandom % 3) == 0,
           $urandom % 256, $urandom % 16, ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    // R1 reset again mid-stream
    @(negedge clk);
    rst = 1; go = 0;
    @(posedge clk);
    m_a = 0; m_b = 0; m_res = 0; m_cf = 0; m_sf = 0; m_zf = 0; m_pf = 0;
    #2;
    compare("R1");
    rst = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule